// File: doc/BRIEF.md
# Eight-Channel DMA Control and Status Register Block

This block is the software-visible register file and interrupt combiner for an eight-channel DMA controller. A processor reaches it over a simple 32-bit memory-mapped read/write bus with a combinational read path. The block holds a packed mode and direction word with one 4-bit slot per channel. It holds a second word that combines interrupt enables with start requests. A spare general-purpose control word completes the control set. A 16-byte descriptor window per channel stores device address, memory address, size and next-link words. These are presented to the channel engines on a flat bus.

Each channel engine feeds back a 2-bit live state code, a completion pulse and an error pulse. The block turns those into sticky interrupt and error flags, cleared by writing ones, and returns the state codes unregistered in the upper half of the status word. A single interrupt output is raised while any enabled channel has its interrupt flag set. Start requests become one-cycle pulses to idle engines. A channel whose mode is set to disabled sees its abort line asserted, which forces that engine back to idle.

Top module: `dmach_csr`

## Requirements
- R1: After reset every control word, every flag and every descriptor word reads 0, chStart and irqOut are 0, chMode is 0 and chAbort is all ones.
- R2: Word 0x00 holds a 4-bit slot per channel at bit 4*ch: bits [1:0] are the mode (0 disabled, 1 chained, 2 single-shot), bit 2 the direction (1 memory to device). Bit 3 reads 0. chMode[2*ch+1:2*ch] and chDir[ch] show the stored fields from the cycle after the write.
- R3: chAbort[ch] is 1 exactly while channel ch's mode field is 0, starting the cycle after the write that sets it.
- R4: In word 0x08, bits [7:0] are read/write interrupt enables. Writing 1 to bit 8+ch while engState[ch] is 0 (idle) drives chStart[ch] high for the single cycle after the write. Bits [31:8] read 0.
- R5: A start request to a channel whose engState is not 0 at the write produces no chStart pulse.
- R6: engDone[ch] sets interrupt flag bit ch of word 0x10. engErr[ch] sets both bit ch and error bit 8+ch.
- R7: Writing word 0x10 clears each interrupt bit written as 1, together with the error bit of that channel. An error bit written as 1 clears only itself. Bits written as 0 are unchanged. A set event in the same cycle as a clear wins.
- R8: Word 0x10 bits [17+2*ch:16+2*ch] return engState for channel ch in the same cycle.
- R9: irqOut is 1 while any channel has both its interrupt flag and its enable set, and 0 otherwise.
- R10: Channel ch's descriptor window at 0x20+16*ch holds four read/write words at offsets 0, 4, 8 and 12. Word w appears on descData[ch*128+w*32 +: 32].
- R11: Word 0x04 is a plain 32-bit read/write word. Word 0x14, reserved offsets 0x0C, 0x18 and 0x1C, addresses at or above 0xA0 and addresses with nonzero low two bits read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| engState | input | 16 | Per-channel 2-bit engine state, channel ch at [2ch+1:2ch] |
| engDone | input | 8 | Per-channel completion pulse |
| engErr | input | 8 | Per-channel error pulse |
| chMode | output | 16 | Per-channel mode field |
| chDir | output | 8 | Per-channel direction |
| chStart | output | 8 | Per-channel one-cycle start pulse |
| chAbort | output | 8 | Per-channel abort, high while mode is disabled |
| descData | output | 1024 | All descriptor words, 128 bits per channel |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A wrong stored mode or direction shows on chMode, chDir and chAbort one cycle after the offending write, and on the next read of word 0x00. A flag held wrong appears on the next read of word 0x10 and on irqOut in the same cycle as the bad update, since the interrupt path has no register after the flags. A mis-gated start shows as a pulse in the cycle after the write, or as a missing pulse, and a stuck start shows as a pulse lasting past one cycle. Descriptor decode errors surface as a word landing in the wrong slice of descData.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int NUM_CH      = 8;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int SLOT_W      = 4;
  localparam int STATE_W     = 2;
  localparam int DESC_WORDS  = 4;
  localparam int CH_W        = $clog2(NUM_CH);
  localparam int WORD_W      = $clog2(DESC_WORDS);

  localparam int OFF_CTL0    = 'h00;
  localparam int OFF_CTL1    = 'h04;
  localparam int OFF_CTL2    = 'h08;
  localparam int OFF_STS0    = 'h10;
  localparam int OFF_STS1    = 'h14;
  localparam int DESC_BASE   = 'h20;
  localparam int DESC_STRIDE = DESC_WORDS * 4;
  localparam int DESC_END    = DESC_BASE + DESC_STRIDE * NUM_CH;

  localparam int START_LSB   = 8;
  localparam int ERR_LSB     = 8;
  localparam int STATE_LSB   = 16;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] ST_IDLE    = 2'd0;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_CTL0, SEL_CTL1, SEL_CTL2, SEL_STS0, SEL_DESC
  } rdSel_e;

  typedef struct packed {
    logic              wrCtl0;
    logic              wrCtl1;
    logic              wrCtl2;
    logic              wrSts0;
    logic              wrDesc;
    logic [CH_W-1:0]   descCh;
    logic [WORD_W-1:0] descWord;
    rdSel_e            rdSel;
  } csrStrobe_t;
endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
  import dmach_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output csrStrobe_t        strb
);
  logic [ADDR_W-1:0] descOffs;
  logic              wrAcc;
  logic              descHit;

  assign wrAcc    = busSel && busWrite;
  assign descOffs = busAddr - ADDR_W'(DESC_BASE);
  assign descHit  = (busAddr >= ADDR_W'(DESC_BASE)) &&
                    (int'(busAddr) < DESC_END) &&
                    (descOffs[1:0] == 2'b00);

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_ZERO;
    strb.descCh   = CH_W'(descOffs >> 4);
    strb.descWord = descOffs[WORD_W+1:2];
    if (descHit) begin
      strb.rdSel  = SEL_DESC;
      strb.wrDesc = wrAcc;
    end else begin
      case (busAddr)
        ADDR_W'(OFF_CTL0): begin strb.rdSel = SEL_CTL0; strb.wrCtl0 = wrAcc; end
        ADDR_W'(OFF_CTL1): begin strb.rdSel = SEL_CTL1; strb.wrCtl1 = wrAcc; end
        ADDR_W'(OFF_CTL2): begin strb.rdSel = SEL_CTL2; strb.wrCtl2 = wrAcc; end
        ADDR_W'(OFF_STS0): begin strb.rdSel = SEL_STS0; strb.wrSts0 = wrAcc; end
        default:           strb.rdSel = SEL_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/dmach_chan_slot.sv
module dmach_chan_slot
  import dmach_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrCtl0,
  input  logic [2:0]         ctlNib,
  input  logic               wrCtl2,
  input  logic               enBit,
  input  logic               startBit,
  input  logic               wrSts0,
  input  logic               clrIrq,
  input  logic               clrErr,
  input  logic [STATE_W-1:0] engState,
  input  logic               engDone,
  input  logic               engErr,
  output logic [1:0]         mode,
  output logic               dir,
  output logic               irqEn,
  output logic               start,
  output logic               irqFlag,
  output logic               errFlag,
  output logic               abort,
  output logic               irqReq
);
  logic setIrq;
  assign setIrq = engDone || engErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_OFF;
      dir     <= 1'b0;
      irqEn   <= 1'b0;
      start   <= 1'b0;
      irqFlag <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (wrCtl0) begin
        mode <= ctlNib[1:0];
        dir  <= ctlNib[2];
      end
      if (wrCtl2) irqEn <= enBit;
      start <= wrCtl2 && startBit && (engState == ST_IDLE);
      if (setIrq)                irqFlag <= 1'b1;
      else if (wrSts0 && clrIrq) irqFlag <= 1'b0;
      if (engErr)                          errFlag <= 1'b1;
      else if (wrSts0 && (clrIrq || clrErr)) errFlag <= 1'b0;
    end
  end

  assign abort  = (mode == MODE_OFF);
  assign irqReq = irqFlag && irqEn;

  p_mode_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl0 |=> (mode == $past(ctlNib[1:0]) && dir == $past(ctlNib[2])));
  p_start_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    start |-> $past(wrCtl2 && startBit));
  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    start |-> $past(engState == ST_IDLE));
  p_event_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    setIrq |=> irqFlag);
  p_err_pairs_r6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> irqFlag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrSts0 && clrIrq && !setIrq) |=> (!irqFlag && !errFlag));
endmodule

// File: rtl/dmach_datapath.sv
module dmach_datapath
  import dmach_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  csrStrobe_t                            strb,
  input  logic [DATA_W-1:0]                     busWdata,
  output logic [DATA_W-1:0]                     busRdata,
  input  logic [NUM_CH*STATE_W-1:0]             engState,
  input  logic [NUM_CH-1:0]                     engDone,
  input  logic [NUM_CH-1:0]                     engErr,
  output logic [NUM_CH*2-1:0]                   chMode,
  output logic [NUM_CH-1:0]                     chDir,
  output logic [NUM_CH-1:0]                     chStart,
  output logic [NUM_CH-1:0]                     chAbort,
  output logic [NUM_CH*DESC_WORDS*DATA_W-1:0]   descData,
  output logic                                  irqOut
);
  localparam int DESC_TOTAL = NUM_CH * DESC_WORDS;

  logic [NUM_CH-1:0] irqEn, irqFlag, errFlag, irqReq;
  logic [DATA_W-1:0] ctl1Word;
  logic [DATA_W-1:0] ctl0Word, ctl2Word, sts0Word;
  logic [DATA_W-1:0] descMem [DESC_TOTAL];
  logic [CH_W+WORD_W-1:0] descIdx;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    dmach_chan_slot u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .wrCtl0   (strb.wrCtl0),
      .ctlNib   (busWdata[SLOT_W*ch +: 3]),
      .wrCtl2   (strb.wrCtl2),
      .enBit    (busWdata[ch]),
      .startBit (busWdata[START_LSB+ch]),
      .wrSts0   (strb.wrSts0),
      .clrIrq   (busWdata[ch]),
      .clrErr   (busWdata[ERR_LSB+ch]),
      .engState (engState[STATE_W*ch +: STATE_W]),
      .engDone  (engDone[ch]),
      .engErr   (engErr[ch]),
      .mode     (chMode[2*ch +: 2]),
      .dir      (chDir[ch]),
      .irqEn    (irqEn[ch]),
      .start    (chStart[ch]),
      .irqFlag  (irqFlag[ch]),
      .errFlag  (errFlag[ch]),
      .abort    (chAbort[ch]),
      .irqReq   (irqReq[ch])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctl1Word <= '0;
    else if (strb.wrCtl1) ctl1Word <= busWdata;
  end

  assign descIdx = {strb.descCh, strb.descWord};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_TOTAL; i++) descMem[i] <= '0;
    end else if (strb.wrDesc) begin
      descMem[descIdx] <= busWdata;
    end
  end

  for (genvar k = 0; k < DESC_TOTAL; k++) begin : g_desc_out
    assign descData[DATA_W*k +: DATA_W] = descMem[k];
  end

  always_comb begin
    ctl0Word = '0;
    ctl2Word = '0;
    sts0Word = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      ctl0Word[SLOT_W*ch +: SLOT_W] = {1'b0, chDir[ch], chMode[2*ch +: 2]};
      ctl2Word[ch]                  = irqEn[ch];
      sts0Word[ch]                  = irqFlag[ch];
      sts0Word[ERR_LSB+ch]          = errFlag[ch];
      sts0Word[STATE_LSB+STATE_W*ch +: STATE_W] = engState[STATE_W*ch +: STATE_W];
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CTL0: busRdata = ctl0Word;
      SEL_CTL1: busRdata = ctl1Word;
      SEL_CTL2: busRdata = ctl2Word;
      SEL_STS0: busRdata = sts0Word;
      SEL_DESC: busRdata = descMem[descIdx];
      default:  busRdata = '0;
    endcase
  end

  assign irqOut = |irqReq;

  p_desc_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDesc |=> (descMem[$past(descIdx)] == $past(busWdata)));
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == '0) |-> !irqOut);
endmodule

// File: rtl/dmach_csr.sv
module dmach_csr
  import dmach_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                busSel,
  input  logic                                busWrite,
  input  logic [ADDR_W-1:0]                   busAddr,
  input  logic [DATA_W-1:0]                   busWdata,
  output logic [DATA_W-1:0]                   busRdata,
  input  logic [NUM_CH*STATE_W-1:0]           engState,
  input  logic [NUM_CH-1:0]                   engDone,
  input  logic [NUM_CH-1:0]                   engErr,
  output logic [NUM_CH*2-1:0]                 chMode,
  output logic [NUM_CH-1:0]                   chDir,
  output logic [NUM_CH-1:0]                   chStart,
  output logic [NUM_CH-1:0]                   chAbort,
  output logic [NUM_CH*DESC_WORDS*DATA_W-1:0] descData,
  output logic                                irqOut
);
  csrStrobe_t strb;

  dmach_decode u_decode (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  dmach_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .engState (engState),
    .engDone  (engDone),
    .engErr   (engErr),
    .chMode   (chMode),
    .chDir    (chDir),
    .chStart  (chStart),
    .chAbort  (chAbort),
    .descData (descData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/dmach_csr_tb.sv
module dmach_csr_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0;
  logic         busWrite = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [15:0]  engState = '0;
  logic [7:0]   engDone = '0;
  logic [7:0]   engErr = '0;
  logic [15:0]  chMode;
  logic [7:0]   chDir, chStart, chAbort;
  logic [1023:0] descData;
  logic         irqOut;

  int errors = 0;
  int checks = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  dmach_csr u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .engState(engState), .engDone(engDone), .engErr(engErr),
    .chMode(chMode), .chDir(chDir), .chStart(chStart), .chAbort(chAbort),
    .descData(descData), .irqOut(irqOut)
  );

  // {isWrite, addr, data, expected read}
  localparam int NV = 20;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h7777_7777},   // R2 bit 3 reads 0
    {1'b1, 8'h00, 32'h0000_4521, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h0000_4521},   // R2
    {1'b1, 8'h04, 32'hA5A5_5A5A, 32'h0},
    {1'b0, 8'h04, 32'h0,         32'hA5A5_5A5A},   // R11
    {1'b1, 8'h08, 32'hFFFF_00C3, 32'h0},
    {1'b0, 8'h08, 32'h0,         32'h0000_00C3},   // R4 upper bits read 0
    {1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h0C, 32'h0,         32'h0},           // R11
    {1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h14, 32'h0,         32'h0},           // R11
    {1'b0, 8'h1C, 32'h0,         32'h0},           // R11
    {1'b1, 8'h20, 32'h1111_0000, 32'h0},
    {1'b1, 8'h2C, 32'h2222_000C, 32'h0},
    {1'b1, 8'h94, 32'h3333_0094, 32'h0},
    {1'b0, 8'h20, 32'h0,         32'h1111_0000},   // R10
    {1'b0, 8'h2C, 32'h0,         32'h2222_000C},   // R10
    {1'b0, 8'h94, 32'h0,         32'h3333_0094},   // R10
    {1'b0, 8'h22, 32'h0,         32'h0}            // R11 unaligned
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] done, input logic [7:0] err);
    @(negedge clk);
    engDone = done; engErr = err;
    @(negedge clk);
    engDone = '0; engErr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 chStart", 32'(chStart), 32'h0);
    check("R1 chAbort", 32'(chAbort), 32'hFF);
    check("R1 chMode", 32'(chMode), 32'h0);
    check("R1 irqOut", 32'(irqOut), 32'h0);
    check("R1 desc", descData[31:0] | descData[1023:992], 32'h0);
    busRd(8'h00, rd); check("R1 ctl0", rd, 32'h0);
    busRd(8'h08, rd); check("R1 ctl2", rd, 32'h0);
    busRd(8'h10, rd); check("R1 sts0", rd, 32'h0);
    busRd(8'h9C, rd); check("R1 desc7", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) busWr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        busRd(VEC[i][71:64], rd);
        check($sformatf("vector %0d R2/R4/R10/R11", i), rd, VEC[i][31:0]);
      end
    end

    // R2 outputs for control word 0x4521
    check("R2 chMode", 32'(chMode), 32'h0019);
    check("R2 chDir", 32'(chDir), 32'h0C);
    check("R3 chAbort", 32'(chAbort), 32'hF8);
    busWr(8'h00, 32'h0000_4501);
    check("R3 abort after disable", 32'(chAbort), 32'hFA);

    // R10 descriptor outputs
    check("R10 ch0 w0", descData[31:0], 32'h1111_0000);
    check("R10 ch0 w3", descData[127:96], 32'h2222_000C);
    check("R10 ch7 w1", descData[7*128+32 +: 32], 32'h3333_0094);

    // R4 start pulse
    busWr(8'h08, 32'h0000_0401);
    check("R4 start pulse", 32'(chStart), 32'h04);
    @(negedge clk);
    check("R4 start one cycle", 32'(chStart), 32'h0);
    busRd(8'h08, rd); check("R4 enables", rd, 32'h01);

    // R5 start to busy channel ignored
    engState = 16'h0080;
    busWr(8'h08, 32'h0000_0801);
    check("R5 busy start ignored", 32'(chStart), 32'h0);
    @(negedge clk);
    check("R5 busy start stays low", 32'(chStart), 32'h0);

    // R8 live state
    engState = 16'h1B4E;
    busRd(8'h10, rd); check("R8 live state", rd, 32'h1B4E_0000);
    engState = '0;

    // R6 flag setting
    pulse(8'h01, 8'h00);
    busRd(8'h10, rd); check("R6 done flag", rd, 32'h0000_0001);
    check("R9 irq enabled ch0", 32'(irqOut), 32'h1);
    pulse(8'h00, 8'h20);
    busRd(8'h10, rd); check("R6 err sets both", rd, 32'h0000_2021);

    // R9 enable gating
    busWr(8'h10, 32'h0000_0001);
    busRd(8'h10, rd); check("R7 clear ch0", rd, 32'h0000_2020);
    check("R9 irq masked", 32'(irqOut), 32'h0);
    busWr(8'h08, 32'h0000_0020);
    check("R9 irq after enable", 32'(irqOut), 32'h1);

    // R7 write-one-to-clear
    busWr(8'h10, 32'h0000_2000);
    busRd(8'h10, rd); check("R7 err only cleared", rd, 32'h0000_0020);
    busWr(8'h10, 32'h0000_0020);
    busRd(8'h10, rd); check("R7 irq cleared", rd, 32'h0);
    check("R9 irq low", 32'(irqOut), 32'h0);
    pulse(8'h00, 8'h40);
    busWr(8'h10, 32'h0000_0040);
    busRd(8'h10, rd); check("R7 irq clear takes err", rd, 32'h0);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h10; busWdata = 32'h2; engDone = 8'h02;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; engDone = '0;
    busRd(8'h10, rd); check("R7 set wins", rd, 32'h0000_0002);
    busWr(8'h10, 32'h0);
    busRd(8'h10, rd); check("R7 zero write no effect", rd, 32'h0000_0002);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule